// File: doc/BRIEF.md
# Lockable Watchdog Countdown Timer

This block is a down counter that serves either as a general-purpose interval timer or as a watchdog. Software writes a reload value and a control word, and the counter then steps down by one on every prescaled tick. A tick comes from one of two sources: every system clock cycle, or pulses on a slow-clock enable input. The prescaler divides that source by 1, 16 or 256. In general mode, a tick that finds the count at zero raises an interrupt. The counter then either wraps to full scale (free-running) or reloads the stored value (periodic).

Setting the watchdog enable bit does four things. It locks the reload and control registers, and later writes to them are ignored until reset. It forces the tick source to the slow-clock enable. It keeps the counter running. It routes expiry to one of two actions chosen by a control bit: a one-cycle reset request, or the interrupt. A write of any value to the clear register restarts the timeout from the reload value and drops a pending interrupt. Software services the watchdog by writing the clear register at regular intervals.

Top module: `lockable_wdt`

## Requirements
- R1: After reset the count is 0, the interrupt and reset request outputs are low and the lock output is low.
- R2: An accepted write to the control register (select code 01) loads the count from the reload register (select code 00) and restarts the prescaler.
- R3: Each prescaled tick lowers a nonzero count by one. The prescale field is control bits [2:1]: 00 gives a tick for every source tick, 01 every 16th, 10 every 256th, and 11 every one.
- R4: Control bit 6 selects the tick source: 0 is every clock cycle, 1 is the slow-clock enable input. In watchdog mode the slow-clock enable is always the source.
- R5: In general mode with control bit 3 at 0 (free-running), a tick at count zero sets the count to all ones and sets the interrupt.
- R6: In general mode with control bit 3 at 1 (periodic), a tick at count zero loads the reload value and sets the interrupt.
- R7: In watchdog mode (control bit 4), a tick at count zero loads the reload value. If control bit 5 is 1, the tick produces a reset request pulse one cycle long and leaves the interrupt unchanged. If control bit 5 is 0, it sets the interrupt.
- R8: A write of any data to the clear register (select code 10) loads the count from the reload register, clears the interrupt and restarts the prescaler. If it lands in the same cycle as an expiry, the expiry is suppressed.
- R9: Once control bit 4 has been written as 1, the lock output is high. Writes to the reload and control registers then have no effect until reset, and the watchdog keeps running.
- R10: The interrupt stays set until a clear-register write or a reset.
- R11: With control bit 0 (run) at 0 and watchdog mode off, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle enable pulses from the slow clock domain |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 00 reload, 01 control, 10 clear, 11 none |
| wr_data | input | CNT_W | Write data; the control word uses bits [6:0] |
| count_o | output | CNT_W | Current count |
| irq_o | output | 1 | Sticky expiry interrupt |
| rst_req_o | output | 1 | One-cycle watchdog reset request |
| locked_o | output | 1 | Watchdog mode active, configuration locked |

## Verification
A clear-register write and a counter expiry can land on the same clock edge. In that case the service must win: the count reloads and no interrupt is raised. The bench runs a periodic count down to zero and places the clear write exactly on the edge whose tick would expire it. It then checks that the count shows the reload value and that the interrupt is still low. A second case writes the clear register while an interrupt is already pending. It checks that the interrupt drops and the count restarts together.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   typedef enum logic [1:0] {
      SEL_LOAD  = 2'b00,
      SEL_CTRL  = 2'b01,
      SEL_CLEAR = 2'b10,
      SEL_NONE  = 2'b11
   } wsel_e;

   // bit 6 down to bit 0
   typedef struct packed {
      logic       slow_src;
      logic       act_rst;
      logic       wd_en;
      logic       periodic;
      logic [1:0] pre_sel;
      logic       run_en;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

   localparam logic [1:0] PRE_DIV1   = 2'b00;
   localparam logic [1:0] PRE_DIVMID = 2'b01;
   localparam logic [1:0] PRE_DIVMAX = 2'b10;

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
   import wdt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] load_o,
   output ctrl_t            ctrl_o,
   output logic             restart_o,
   output logic             clear_o,
   output logic             locked_o
);

   logic [CNT_W-1:0] load_q;
   ctrl_t            ctrl_q;
   logic             ld_hit, ct_hit, clr_hit;

   assign ld_hit  = wr_en && (wr_sel == SEL_LOAD)  && !ctrl_q.wd_en;
   assign ct_hit  = wr_en && (wr_sel == SEL_CTRL)  && !ctrl_q.wd_en;
   assign clr_hit = wr_en && (wr_sel == SEL_CLEAR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         load_q <= '0;
         ctrl_q <= '0;
      end else begin
         if (ld_hit) load_q <= wr_data;
         if (ct_hit) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
      end
   end

   assign load_o    = load_q;
   assign ctrl_o    = ctrl_q;
   assign restart_o = clr_hit | ct_hit;
   assign clear_o   = clr_hit;
   assign locked_o  = ctrl_q.wd_en;

   AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      locked_o |=> locked_o); // R9
   AST_LOCKED_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      locked_o |=> $stable(load_q)); // R9
   AST_LOCKED_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      locked_o |=> $stable(ctrl_q)); // R9

endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale
   import wdt_pkg::*;
#(
   parameter int MID_LOG = 4,
   parameter int MAX_LOG = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic       run,
   input  logic       src_tick,
   input  logic [1:0] pre_sel,
   output logic       tick_o
);

   if (MID_LOG < 0 || MID_LOG > MAX_LOG) begin : g_bad_mid
      $error("wdt_prescale: MID_LOG must lie in 0..MAX_LOG");
   end
   if (MAX_LOG > 16) begin : g_bad_max
      $error("wdt_prescale: MAX_LOG above 16 is not supported");
   end

   if (MAX_LOG == 0) begin : g_nodiv
      assign tick_o = run && src_tick;
   end else begin : g_div
      localparam int PW = MAX_LOG;
      localparam logic [PW-1:0] LIM_MID = PW'((1 << MID_LOG) - 1);
      localparam logic [PW-1:0] LIM_MAX = PW'((1 << MAX_LOG) - 1);

      logic [PW-1:0] pcnt_q;
      logic [PW-1:0] lim;
      logic          at_lim;

      always_comb begin
         unique case (pre_sel)
            PRE_DIVMID: lim = LIM_MID;
            PRE_DIVMAX: lim = LIM_MAX;
            default:    lim = '0;
         endcase
      end

      assign at_lim = (pcnt_q >= lim);
      assign tick_o = run && src_tick && at_lim;

      always_ff @(posedge clk) begin
         if (!rst_n || restart) begin
            pcnt_q <= '0;
         end else if (run && src_tick) begin
            pcnt_q <= at_lim ? '0 : pcnt_q + 1'b1;
         end
      end

      AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
         restart |=> (pcnt_q == '0)); // R2
   end

endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             tick,
   input  logic             reload_at_zero,
   input  logic [CNT_W-1:0] load,
   output logic [CNT_W-1:0] count_o,
   output logic             expire_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             zero;

   assign zero     = (cnt_q == '0);
   assign expire_o = tick && zero && !restart;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= load;
      end else if (tick) begin
         if (!zero)               cnt_q <= cnt_q - 1'b1;
         else if (reload_at_zero) cnt_q <= load;
         else                     cnt_q <= '1;
      end
   end

   assign count_o = cnt_q;

   AST_RESTART_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt_q == $past(load))); // R8
   AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !restart && !zero) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3
   AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_o && !reload_at_zero) |=> (&cnt_q)); // R5

endmodule

// File: rtl/wdt_event.sv
module wdt_event (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic clear,
   input  logic wd_mode,
   input  logic act_rst,
   output logic irq_o,
   output logic rst_req_o
);

   logic irq_q, rst_q;
   logic to_rst;

   assign to_rst = wd_mode && act_rst;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         rst_q <= 1'b0;
      end else begin
         rst_q <= expire && to_rst;
         if (clear)                  irq_q <= 1'b0;
         else if (expire && !to_rst) irq_q <= 1'b1;
      end
   end

   assign irq_o     = irq_q;
   assign rst_req_o = rst_q;

   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !clear) |=> irq_q); // R10
   AST_RST_ONLY_WD: assert property (@(posedge clk) disable iff (!rst_n)
      rst_q |-> wd_mode); // R7
   AST_RST_KEEPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      rst_q |-> $stable(irq_q)); // R7

endmodule

// File: rtl/lockable_wdt.sv
module lockable_wdt
   import wdt_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int PRE_MID_LOG = 4,
   parameter int PRE_MAX_LOG = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slow_tick,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] count_o,
   output logic             irq_o,
   output logic             rst_req_o,
   output logic             locked_o
);

   if (CNT_W < CTRL_W) begin : g_bad_width
      $error("lockable_wdt: CNT_W must hold the control word");
   end

   logic [CNT_W-1:0] load;
   ctrl_t            ctrl;
   logic             restart, clear, locked;
   logic             run, src_tick, tick, expire, reload_at_zero;

   wdt_regs #(.CNT_W(CNT_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .load_o   (load),
      .ctrl_o   (ctrl),
      .restart_o(restart),
      .clear_o  (clear),
      .locked_o (locked)
   );

   assign run            = ctrl.run_en | ctrl.wd_en;
   assign src_tick       = (ctrl.slow_src | ctrl.wd_en) ? slow_tick : 1'b1;
   assign reload_at_zero = ctrl.periodic | ctrl.wd_en;

   wdt_prescale #(.MID_LOG(PRE_MID_LOG), .MAX_LOG(PRE_MAX_LOG)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .run     (run),
      .src_tick(src_tick),
      .pre_sel (ctrl.pre_sel),
      .tick_o  (tick)
   );

   wdt_count #(.CNT_W(CNT_W)) u_cnt (
      .clk           (clk),
      .rst_n         (rst_n),
      .restart       (restart),
      .tick          (tick),
      .reload_at_zero(reload_at_zero),
      .load          (load),
      .count_o       (count_o),
      .expire_o      (expire)
   );

   wdt_event u_evt (
      .clk      (clk),
      .rst_n    (rst_n),
      .expire   (expire),
      .clear    (clear),
      .wd_mode  (ctrl.wd_en),
      .act_rst  (ctrl.act_rst),
      .irq_o    (irq_o),
      .rst_req_o(rst_req_o)
   );

   assign locked_o = locked;

   AST_HALT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !restart) |=> $stable(count_o)); // R11
   AST_WD_SLOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !slow_tick && !restart) |=> $stable(count_o)); // R4

endmodule

// File: tb/tb_lockable_wdt.sv
module tb_lockable_wdt;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         slow_tick = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_sel = 2'b11;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] count_o;
   logic         irq_o, rst_req_o, locked_o;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   lockable_wdt #(.CNT_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .count_o(count_o), .irq_o(irq_o), .rst_req_o(rst_req_o),
      .locked_o(locked_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   // called at a negedge; returns at the negedge after the write edge
   task automatic wr(input logic [1:0] sel, input logic [W-1:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_sel = 2'b11; wr_data = '0;
   endtask

   task automatic pulse_slow();
      slow_tick = 1'b1;
      @(negedge clk);
      slow_tick = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      step(2);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      chk("R1 count", count_o, 0);
      chk("R1 irq", irq_o, 0);
      chk("R1 rst_req", rst_req_o, 0);
      chk("R1 locked", locked_o, 0);
   endtask

   task automatic t_periodic();
      wr(2'b00, 16'd5);
      wr(2'b01, 16'h0009);
      chk("R2 ctrl write loads", count_o, 5);
      step(3);
      chk("R3 down by one", count_o, 2);
      step(3);
      chk("R6 periodic reload", count_o, 5);
      chk("R6 irq set", irq_o, 1);
      step(2);
      chk("R10 irq held", irq_o, 1);
      chk("R3 after reload", count_o, 3);
      wr(2'b10, 16'hBEEF);
      chk("R8 clear reloads", count_o, 5);
      chk("R8 clear drops irq", irq_o, 0);
   endtask

   task automatic t_free();
      wr(2'b00, 16'd2);
      wr(2'b01, 16'h0001);
      step(3);
      chk("R5 wrap to full scale", count_o, 16'hFFFF);
      chk("R5 irq set", irq_o, 1);
      wr(2'b10, 16'h0);
   endtask

   task automatic t_prescale();
      wr(2'b00, 16'd3);
      wr(2'b01, 16'h0003);
      step(15);
      chk("R3 div16 before", count_o, 3);
      step(1);
      chk("R3 div16 tick", count_o, 2);
      wr(2'b01, 16'h0005);
      step(255);
      chk("R3 div256 before", count_o, 3);
      step(1);
      chk("R3 div256 tick", count_o, 2);
      wr(2'b01, 16'h0007);
      step(1);
      chk("R3 code 11 divides by one", count_o, 2);
   endtask

   task automatic t_slow_and_halt();
      wr(2'b00, 16'd4);
      wr(2'b01, 16'h0041);
      step(5);
      chk("R4 slow source idle", count_o, 4);
      pulse_slow();
      pulse_slow();
      chk("R4 slow source ticks", count_o, 2);
      wr(2'b01, 16'h0000);
      step(10);
      chk("R11 halted", count_o, 4);
   endtask

   task automatic t_collide();
      wr(2'b00, 16'd3);
      wr(2'b01, 16'h0009);
      step(3);
      chk("R8 at zero", count_o, 0);
      wr(2'b10, 16'h1234);
      chk("R8 clear wins count", count_o, 3);
      chk("R8 clear wins irq", irq_o, 0);
   endtask

   task automatic t_wd_irq();
      wr(2'b00, 16'd2);
      wr(2'b01, 16'h0010);
      chk("R9 locked", locked_o, 1);
      chk("R9 wd load", count_o, 2);
      step(3);
      chk("R4 wd ignores clock ticks", count_o, 2);
      pulse_slow(); pulse_slow(); pulse_slow();
      chk("R7 wd irq action", irq_o, 1);
      chk("R7 wd reload", count_o, 2);
      chk("R7 no reset request", rst_req_o, 0);
      wr(2'b00, 16'd9);
      wr(2'b10, 16'h0);
      chk("R9 load write ignored", count_o, 2);
      chk("R8 wd clear drops irq", irq_o, 0);
      wr(2'b01, 16'h0000);
      chk("R9 ctrl write ignored", locked_o, 1);
      pulse_slow();
      chk("R9 keeps running", count_o, 1);
      do_reset();
      chk("R9 reset unlocks", locked_o, 0);
   endtask

   task automatic t_wd_rst();
      wr(2'b00, 16'd1);
      wr(2'b01, 16'h0030);
      pulse_slow();
      chk("R7 count zero", count_o, 0);
      pulse_slow();
      chk("R7 reset request", rst_req_o, 1);
      chk("R7 irq untouched", irq_o, 0);
      chk("R7 reload", count_o, 1);
      step(1);
      chk("R7 one cycle pulse", rst_req_o, 0);
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      t_reset();
      t_periodic();
      t_free();
      t_prescale();
      t_slow_and_halt();
      t_collide();
      t_wd_irq();
      t_wd_rst();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule